// File: doc/BRIEF.md
# Single-Bit Manipulation Execution Unit

This block decodes and executes a family of four instructions that act on one bit of an 8-bit or 16-bit operand: test a bit, clear a bit, set a bit and invert a bit. Each cycle the surrounding pipeline presents the escape byte, the second opcode byte, the addressing byte, an optional immediate byte, the already-fetched operand value and the current value of the count register. One clock later the block returns the updated operand with a write-enable, the flag updates, and the destination description (register or memory, register code, width) that the writeback stage needs.

The second opcode byte carries all of the variation. Its bits 2:1 pick the operation, bit 3 picks where the bit index comes from and bit 0 picks the operand width. The bit index is masked to the operand width, so an index of 11 on a byte operand addresses bit 3. Only the test operation touches flags; the other three write the operand back and leave every flag alone. Operand fetch, effective-address generation and the writeback itself are outside this block.

Top module: `bitop_unit`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, every output goes to 0 at that edge, so after reset `out_valid`, `wr_en`, `flag_we`, `illegal_op` and `result_val` read 0.
- R2: An instruction is legal when `esc_byte` is 0x0F and `op_byte[7:4]` is 0x1; then `op_byte[2:1]` selects the operation (00 test, 01 clear, 10 set, 11 invert), `op_byte[0]` selects width (0 byte, 1 word), and all results appear at the outputs on the clock edge after the one that sampled `in_valid` high.
- R3: When `op_byte[3]` is 0 the bit index is taken from `cnt_val`; when it is 1 it is taken from `imm_byte`; the unselected source has no effect on any output.
- R4: The bit index is the low 3 bits of the chosen source for byte operands and the low 4 bits for word operands.
- R5: A legal test sets `flag_we` to 1, `zf_out` to the inverse of the selected operand bit, `cf_out` and `of_out` to 0, keeps `wr_en` at 0, and returns the width-masked operand unchanged on `result_val`.
- R6: A legal clear, set or invert sets `wr_en` to 1 and `flag_we` to 0, and returns the operand with only the selected bit forced to 0, forced to 1 or inverted respectively.
- R7: For byte operands `operand_val[15:8]` is ignored, `result_val[15:8]` is 0 and `wide_op` is 0; for word operands `wide_op` is 1.
- R8: For a legal instruction `dst_is_reg` is 1 exactly when `modrm_byte[7:6]` is 11, and `dst_code` equals `modrm_byte[2:0]`.
- R9: An input with `in_valid` high that is not legal (wrong escape byte, or `op_byte[7:4]` not 0x1) raises `illegal_op` one cycle later with `wr_en`, `flag_we`, `zf_out` and `result_val` all 0.
- R10: A cycle with `in_valid` low yields `out_valid`, `wr_en`, `flag_we` and `illegal_op` all 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| esc_byte | input | 8 | First opcode byte, must be 0x0F |
| op_byte | input | 8 | Second opcode byte: operation, index source, width |
| modrm_byte | input | 8 | Addressing byte: mode in [7:6], r/m code in [2:0] |
| imm_byte | input | 8 | Immediate bit index |
| cnt_val | input | 8 | Count register value used as bit index |
| operand_val | input | 16 | Fetched operand (low byte for byte operations) |
| out_valid | output | 1 | Result outputs valid |
| result_val | output | 16 | Modified (or, for test, unchanged) operand |
| wr_en | output | 1 | Write result back to the destination |
| flag_we | output | 1 | Update zero, carry and overflow flags |
| zf_out | output | 1 | New zero flag |
| cf_out | output | 1 | New carry flag |
| of_out | output | 1 | New overflow flag |
| illegal_op | output | 1 | Undefined opcode seen |
| dst_is_reg | output | 1 | Destination is a register |
| dst_code | output | 3 | Destination register code |
| wide_op | output | 1 | Operation is 16-bit |

## Verification
Every output of the block is registered once, so each result is due exactly one clock edge after the edge that sampled the instruction. The bench drives a new instruction on a falling edge, lets one rising edge capture it, and compares all outputs on the next falling edge, at which point it drives the following instruction; this keeps every comparison a whole half-period away from the capturing edge. The sweep covers every second-byte value with every index 0 to 15 under both index sources, with the unused source and the operand upper byte driven to values that would expose a wrong selection.

// File: rtl/bitop_pkg.sv
// Package: shared types and constants for the single-bit manipulation unit.
// Assumes: opcode field positions are fixed by the instruction encoding.
package bitop_pkg;

    // Escape byte that opens every instruction of the family
    localparam logic [7:0] ESC_CODE  = 8'h0F;
    // Upper nibble of the second byte shared by all legal encodings
    localparam logic [3:0] GROUP_HI  = 4'h1;
    // Addressing-byte mode that selects a register operand
    localparam logic [1:0] MODE_REG  = 2'b11;

    // Operation taken from second-byte bits 2:1
    typedef enum logic [1:0] {
        BOP_TEST = 2'b00,
        BOP_CLR  = 2'b01,
        BOP_SET  = 2'b10,
        BOP_FLIP = 2'b11
    } bop_kind_e;

    // Decoded instruction fields
    typedef struct packed {
        logic      legal;
        bop_kind_e kind;
        logic      wide;
        logic      use_imm;
        logic      dst_reg;
        logic [2:0] dst_code;
    } bop_dec_t;

endpackage

// File: rtl/bitop_decode.sv
// Module: bitop_decode
// Purely combinational decoder of the escape byte, second opcode byte and
// addressing byte into the fields used by the rest of the unit.
// Assumes: the caller qualifies the result with its own valid signal.
module bitop_decode
    import bitop_pkg::*;
(
    input  logic [7:0] esc_byte,
    input  logic [7:0] op_byte,
    input  logic [7:0] modrm_byte,
    output bop_dec_t   dec
);

    // Split the opcode bytes into operation, width, index source and target
    always_comb begin
        dec.legal    = (esc_byte == ESC_CODE) && (op_byte[7:4] == GROUP_HI);
        dec.kind     = bop_kind_e'(op_byte[2:1]);
        dec.wide     = op_byte[0];
        dec.use_imm  = op_byte[3];
        dec.dst_reg  = (modrm_byte[7:6] == MODE_REG);
        dec.dst_code = modrm_byte[2:0];
    end

endmodule

// File: rtl/bitop_index_sel.sv
// Module: bitop_index_sel
// Chooses the bit-index source (count register or immediate) and masks the
// index to the operand width.
// Assumes: IDX_W bits address the wide operand, BIDX_W bits the narrow one.
module bitop_index_sel #(
    parameter int SRC_W  = 8,
    parameter int IDX_W  = 4,
    parameter int BIDX_W = 3
) (
    input  logic [SRC_W-1:0] cnt_val,
    input  logic [SRC_W-1:0] imm_byte,
    input  logic             use_imm,
    input  logic             wide,
    output logic [IDX_W-1:0] bit_idx
);

    localparam int PAD_W = IDX_W - BIDX_W;

    logic [SRC_W-1:0] raw_idx;

    // Pick the index source named by the opcode
    always_comb raw_idx = use_imm ? imm_byte : cnt_val;

    // Keep only the bits that can address the operand width
    always_comb begin
        if (wide) bit_idx = raw_idx[IDX_W-1:0];
        else      bit_idx = {{PAD_W{1'b0}}, raw_idx[BIDX_W-1:0]};
    end

endmodule

// File: rtl/bitop_alu.sv
// Module: bitop_alu
// Per-lane bit operation: tests, clears, sets or inverts the selected bit
// of the operand; lanes above the narrow width are zeroed for byte operands.
// Assumes: bit_idx is already masked to the operand width.
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic [DATA_W-1:0] operand_val,
    input  logic [IDX_W-1:0]  bit_idx,
    input  bop_kind_e         kind,
    input  logic              wide,
    output logic [DATA_W-1:0] result,
    output logic              sel_bit
);

    logic [DATA_W-1:0] lane_sel;
    logic [DATA_W-1:0] lane_src;

    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        localparam bit UPPER = (i >= BYTE_W);

        // Decode the index into a one-hot lane select and gate upper lanes
        always_comb begin
            lane_sel[i] = (bit_idx == IDX_W'(i));
            lane_src[i] = (UPPER && !wide) ? 1'b0 : operand_val[i];
        end

        // Apply the operation to this lane
        always_comb begin
            if (!lane_sel[i]) begin
                result[i] = lane_src[i];
            end else begin
                unique case (kind)
                    BOP_TEST: result[i] = lane_src[i];
                    BOP_CLR:  result[i] = 1'b0;
                    BOP_SET:  result[i] = 1'b1;
                    BOP_FLIP: result[i] = ~lane_src[i];
                    default:  result[i] = lane_src[i];
                endcase
            end
        end
    end

    // Value of the addressed bit, used for the zero flag
    always_comb sel_bit = |(lane_sel & lane_src);

endmodule

// File: rtl/bitop_unit.sv
// Module: bitop_unit (top)
// Single-bit manipulation execution unit. Decodes one instruction per cycle
// and registers the result, write-enable, flag updates and destination.
// Assumes: operand fetch and writeback are done by the surrounding pipeline;
// all outputs are valid one cycle after in_valid.
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int SRC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        esc_byte,
    input  logic [7:0]        op_byte,
    input  logic [7:0]        modrm_byte,
    input  logic [SRC_W-1:0]  imm_byte,
    input  logic [SRC_W-1:0]  cnt_val,
    input  logic [DATA_W-1:0] operand_val,
    output logic              out_valid,
    output logic [DATA_W-1:0] result_val,
    output logic              wr_en,
    output logic              flag_we,
    output logic              zf_out,
    output logic              cf_out,
    output logic              of_out,
    output logic              illegal_op,
    output logic              dst_is_reg,
    output logic [2:0]        dst_code,
    output logic              wide_op
);

    localparam int IDX_W  = $clog2(DATA_W);
    localparam int BIDX_W = $clog2(BYTE_W);

    bop_dec_t          dec;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] alu_res;
    logic              sel_bit;
    logic              go;
    logic              is_test;

    bitop_decode u_decode (
        .esc_byte   (esc_byte),
        .op_byte    (op_byte),
        .modrm_byte (modrm_byte),
        .dec        (dec)
    );

    bitop_index_sel #(
        .SRC_W  (SRC_W),
        .IDX_W  (IDX_W),
        .BIDX_W (BIDX_W)
    ) u_index (
        .cnt_val  (cnt_val),
        .imm_byte (imm_byte),
        .use_imm  (dec.use_imm),
        .wide     (dec.wide),
        .bit_idx  (bit_idx)
    );

    bitop_alu #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W),
        .IDX_W  (IDX_W)
    ) u_alu (
        .operand_val (operand_val),
        .bit_idx     (bit_idx),
        .kind        (dec.kind),
        .wide        (dec.wide),
        .result      (alu_res),
        .sel_bit     (sel_bit)
    );

    // Qualify the decode with the input valid
    always_comb begin
        go      = in_valid && dec.legal;
        is_test = (dec.kind == BOP_TEST);
    end

    // Output stage: one register level for every result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            result_val <= '0;
            wr_en      <= 1'b0;
            flag_we    <= 1'b0;
            zf_out     <= 1'b0;
            illegal_op <= 1'b0;
            dst_is_reg <= 1'b0;
            dst_code   <= '0;
            wide_op    <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            result_val <= go ? alu_res : '0;
            wr_en      <= go && !is_test;
            flag_we    <= go && is_test;
            zf_out     <= go && is_test && !sel_bit;
            illegal_op <= in_valid && !dec.legal;
            dst_is_reg <= go && dec.dst_reg;
            dst_code   <= go ? dec.dst_code : '0;
            wide_op    <= go && dec.wide;
        end
    end

    // Test always clears carry and overflow; other operations do not update flags
    assign cf_out = 1'b0;
    assign of_out = 1'b0;

endmodule

// File: rtl/bitop_unit_chk.sv
// Module: bitop_unit_chk
// Assertion checker bound to bitop_unit; observes ports only.
// Assumes: same parameters as the unit it is bound to.
module bitop_unit_chk #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int SRC_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [7:0]        esc_byte,
    input logic [7:0]        op_byte,
    input logic [7:0]        modrm_byte,
    input logic [SRC_W-1:0]  imm_byte,
    input logic [SRC_W-1:0]  cnt_val,
    input logic [DATA_W-1:0] operand_val,
    input logic              out_valid,
    input logic [DATA_W-1:0] result_val,
    input logic              wr_en,
    input logic              flag_we,
    input logic              zf_out,
    input logic              cf_out,
    input logic              of_out,
    input logic              illegal_op,
    input logic              dst_is_reg,
    input logic [2:0]        dst_code,
    input logic              wide_op
);

    localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'((1 << BYTE_W) - 1);

    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] opnd_view;

    // Hold the operand seen at the capturing edge
    always_ff @(posedge clk) begin
        if (!rst_n) opnd_q <= '0;
        else        opnd_q <= operand_val;
    end

    // Width-masked view of that operand
    always_comb opnd_view = wide_op ? opnd_q : (opnd_q & NARROW_MASK);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !wr_en && !flag_we && !illegal_op);

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> !wr_en && !flag_we && !zf_out && (result_val == '0));

    // R5
    test_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> !wr_en && !cf_out && !of_out && (result_val == opnd_view));

    // R6
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !flag_we && ($countones(result_val ^ opnd_view) <= 1));

    // R7
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !wide_op) |-> ((result_val & ~NARROW_MASK) == '0));

endmodule

bind bitop_unit bitop_unit_chk #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .SRC_W  (SRC_W)
) chk_i (.*);

// File: tb/bitop_unit_tb_top.sv
// Bench for bitop_unit: sweeps every second-byte value with every index,
// both index sources and several addressing bytes, plus escape-byte errors.
module bitop_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  esc_byte = '0;
    logic [7:0]  op_byte = '0;
    logic [7:0]  modrm_byte = '0;
    logic [7:0]  imm_byte = '0;
    logic [7:0]  cnt_val = '0;
    logic [15:0] operand_val = '0;
    logic        out_valid, wr_en, flag_we, zf_out, cf_out, of_out;
    logic        illegal_op, dst_is_reg, wide_op;
    logic [15:0] result_val;
    logic [2:0]  dst_code;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    bitop_unit dut_i (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Drive at a falling edge, compare after one capture edge at the next falling edge
    task automatic apply_and_check(input logic [7:0] esc, input logic [7:0] op,
                                   input logic [7:0] mrm, input logic [3:0] idx,
                                   input logic [15:0] opnd);
        logic        legal, wide, test;
        logic [1:0]  kind;
        logic [3:0]  eidx;
        logic [15:0] vis, exp_res;
        logic        bitv;
        logic [7:0]  sel_src;
        sel_src     = {4'hB, idx} ^ {op[3:0], 4'h0};
        esc_byte    = esc;
        op_byte     = op;
        modrm_byte  = mrm;
        in_valid    = 1'b1;
        operand_val = opnd;
        // R3: the unselected source holds the complement so a wrong pick shows up
        imm_byte    = op[3] ? sel_src : ~sel_src;
        cnt_val     = op[3] ? ~sel_src : sel_src;
        @(negedge clk);
        legal = (esc == 8'h0F) && (op[7:4] == 4'h1);
        wide  = op[0];
        kind  = op[2:1];
        test  = (kind == 2'b00);
        eidx  = wide ? idx : {1'b0, idx[2:0]};
        vis   = wide ? opnd : {8'h00, opnd[7:0]};
        bitv  = vis[eidx];
        exp_res = vis;
        case (kind)
            2'b01: exp_res[eidx] = 1'b0;
            2'b10: exp_res[eidx] = 1'b1;
            2'b11: exp_res[eidx] = ~bitv;
            default: ;
        endcase
        chk(out_valid == 1'b1, "R2", "out_valid", 32'(out_valid), 32'd1);
        if (!legal) begin
            chk(illegal_op && !wr_en && !flag_we && !zf_out && result_val == 16'h0,
                "R9", "illegal outputs",
                {illegal_op, wr_en, flag_we, zf_out, result_val}, {4'b1000, 16'h0});
        end else begin
            chk(!illegal_op, "R2", "legal decode", 32'(illegal_op), 32'd0);
            if (test)
                chk(flag_we && !wr_en && zf_out == !bitv && !cf_out && !of_out,
                    "R5", "test strobes/flags",
                    {flag_we, wr_en, zf_out, cf_out, of_out},
                    {2'b10, !bitv, 2'b00});
            else
                chk(wr_en && !flag_we, "R6", "write strobes",
                    {wr_en, flag_we}, 2'b10);
            chk(result_val == exp_res, wide ? "R4" : "R7", "result (R3 R6 index/op)",
                32'(result_val), 32'(exp_res));
            chk(wide_op == wide, "R7", "wide_op", 32'(wide_op), 32'(wide));
            chk(dst_is_reg == (mrm[7:6] == 2'b11) && dst_code == mrm[2:0],
                "R8", "destination", {dst_is_reg, dst_code},
                {(mrm[7:6] == 2'b11), mrm[2:0]});
        end
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [7:0] mrms [4] = '{8'hC0, 8'hC5, 8'h07, 8'hFB};
        repeat (3) @(negedge clk);
        // R1: outputs cleared by reset
        chk(!out_valid && !wr_en && !flag_we && !illegal_op && result_val == 16'h0,
            "R1", "reset state",
            {out_valid, wr_en, flag_we, illegal_op, result_val}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle input gives quiet outputs
        chk(!out_valid && !wr_en && !flag_we && !illegal_op, "R10", "idle",
            {out_valid, wr_en, flag_we, illegal_op}, 4'b0);
        // Main sweep over all second-byte values and indices
        for (int op = 0; op < 256; op++) begin
            for (int ix = 0; ix < 16; ix++) begin
                logic [15:0] pat;
                pat = 16'((op * 40503 + ix * 20251) ^ 16'h5A3C);
                apply_and_check(8'h0F, 8'(op), mrms[ix % 4], 4'(ix), pat);
            end
        end
        // Wrong escape byte with an otherwise valid opcode
        for (int e = 0; e < 256; e++) begin
            if (e != 8'h0F)
                apply_and_check(8'(e), 8'h16, 8'hC3, 4'(e), 16'hFFFF);
        end
        // Directed boundaries: byte index 15 masks to 7, word index 15 stays 15
        apply_and_check(8'h0F, 8'h1C, 8'hC1, 4'd15, 16'h0000);
        apply_and_check(8'h0F, 8'h1D, 8'h01, 4'd15, 16'h0000);
        apply_and_check(8'h0F, 8'h10, 8'hC0, 4'd0, 16'hFFFE);
        // R10: drop valid and confirm outputs go quiet
        in_valid = 1'b0;
        @(negedge clk);
        chk(!out_valid && !wr_en && !flag_we && !illegal_op, "R10", "idle after traffic",
            {out_valid, wr_en, flag_we, illegal_op}, 4'b0);
        summary();
    end

endmodule